// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block produces the reset strobes for a small network controller. A full reset comes from any of three places: the power-on indication, an active-low external reset pin, or a one-cycle reset command from the host register interface. The external pin is asynchronous. It is first synchronized and then filtered, so short low glitches cause no reset. During a full reset the block drives the register-file reset, the transmit-path reset and the receive-path reset together. Buffer memory has no reset strobe from this block, so its contents survive a full reset.

The block also holds a small control register with two partial-reset bits, one for transmit and one for receive. A partial-reset bit stays set until the host writes it back to 0, and its own path stays in reset for that whole time. Setting a bit also clears that path's companion control bit: the transmit request for the transmit path, and the receive enable for the receive path. The register file is not reset by a partial reset.

After every full reset the block keeps a busy flag high for a set number of clock cycles. Logic outside the block uses this flag to hold off accesses to the line-interface management registers.

Top module: `rst_ctrl_unit`

## Requirements
- R1: While `por_i` is high, `regs_rst_o`, `tx_rst_o`, `rx_rst_o` and `phy_busy_o` are all high and `ctl_q_o` reads 0.
- R2: If `ext_rst_n_i` is held low for at least FILT_CYC consecutive clock cycles, a full reset follows: `regs_rst_o` goes high.
- R3: A low pulse on `ext_rst_n_i` shorter than FILT_CYC cycles causes no reset, and `ctl_q_o` is left unchanged.
- R4: A one-cycle pulse on `host_rst_i` produces exactly CMD_HOLD consecutive cycles of `regs_rst_o`.
- R5: Every full reset asserts `tx_rst_o` and `rx_rst_o` for as long as `regs_rst_o` is high, and it clears all bits of `ctl_q_o`.
- R6: The control word has four fields: bit 0 is the transmit reset, bit 1 the receive reset, bit 2 the transmit request and bit 3 the receive enable. A write with bit 0 set stores bit 2 as 0 and drives `tx_rst_o` high from the second cycle after the write.
- R7: A write with bit 1 set stores bit 3 as 0 and drives `rx_rst_o` high, while the transmit fields and `tx_rst_o` stay as written.
- R8: A partial-reset bit and its reset output stay high until a write clears the bit. With the bit clear, the matching output is low.
- R9: Partial resets never assert `regs_rst_o` or `phy_busy_o`.
- R10: After `regs_rst_o` falls, `phy_busy_o` stays high for exactly LOCK_CYC more cycles and then goes low.
- R11: A new full reset during the lockout restarts the count, so the LOCK_CYC window is measured from the latest reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_i | input | 1 | Power-on indication, active high, synchronous |
| ext_rst_n_i | input | 1 | External reset pin, active low, asynchronous |
| host_rst_i | input | 1 | One-cycle full-reset command from the host |
| ctl_we_i | input | 1 | Control-word write strobe |
| ctl_wdata_i | input | 4 | Control word to write |
| ctl_q_o | output | 4 | Current control word |
| regs_rst_o | output | 1 | Register-file reset |
| tx_rst_o | output | 1 | Transmit-path reset |
| rx_rst_o | output | 1 | Receive-path reset |
| phy_busy_o | output | 1 | Lockout flag for management-register access |

## Verification
The assertions take `por_i` to be synchronous and high from time zero, so every clocked property is disabled until power-on ends. They also expect host control writes and reset commands to be single-cycle strobes. The stimulus follows these rules: it drives every input one time unit after a rising edge, including the external pin, and it makes partial-reset writes only after the lockout from the previous full reset has expired. The bench then measures the pin filter threshold, the command hold length and the lockout length in whole cycles.

// File: rtl/rst_ctrl_pkg.sv
package rst_ctrl_pkg;
  localparam int CTL_W = 4;

  typedef struct packed {
    logic rx_en;
    logic tx_req;
    logic rx_rst;
    logic tx_rst;
  } ctl_t;
endpackage

// File: rtl/rst_pin_filter.sv
module rst_pin_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYC    = 16
) (
  input  logic clk,
  input  logic por_i,
  input  logic pin_n_i,
  output logic hit_o
);
  localparam int CW = $clog2(FILT_CYC + 1);

  logic [SYNC_STAGES-1:0] sq;

  // synchronizer chain, one flop per stage
  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (por_i) sq[0] <= 1'b1;
          else       sq[0] <= pin_n_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (por_i) sq[g] <= 1'b1;
          else       sq[g] <= sq[g-1];
        end
      end
    end
  endgenerate

  logic [CW-1:0] low_cnt;

  // count consecutive low samples, saturate at threshold
  always_ff @(posedge clk) begin
    if (por_i || sq[SYNC_STAGES-1]) low_cnt <= '0;
    else if (low_cnt != CW'(FILT_CYC)) low_cnt <= low_cnt + 1'b1;
  end

  assign hit_o = (low_cnt == CW'(FILT_CYC));
endmodule

// File: rtl/rst_hold_timer.sv
module rst_hold_timer #(
  parameter int LEN = 8
) (
  input  logic clk,
  input  logic clr_i,
  input  logic load_i,
  output logic busy_o
);
  localparam int CW = $clog2(LEN + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (clr_i)            cnt <= '0;
    else if (load_i)      cnt <= CW'(LEN);
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign busy_o = (cnt != '0);
endmodule

// File: rtl/rst_part_ctl.sv
module rst_part_ctl
  import rst_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             full_i,
  input  logic             we_i,
  input  logic [CTL_W-1:0] wdata_i,
  output logic [CTL_W-1:0] ctl_o
);
  ctl_t cur, nxt;

  always_comb begin
    nxt = cur;
    if (we_i) begin
      nxt = ctl_t'(wdata_i);
      // a path held in reset cannot keep its request/enable bit
      if (nxt.tx_rst) nxt.tx_req = 1'b0;
      if (nxt.rx_rst) nxt.rx_en  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (full_i) cur <= '0;
    else        cur <= nxt;
  end

  assign ctl_o = cur;
endmodule

// File: rtl/rst_ctrl_unit.sv
module rst_ctrl_unit
  import rst_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYC    = 16,
  parameter int CMD_HOLD    = 8,
  parameter int LOCK_CYC    = 2500
) (
  input  logic             clk,
  input  logic             por_i,
  input  logic             ext_rst_n_i,
  input  logic             host_rst_i,
  input  logic             ctl_we_i,
  input  logic [CTL_W-1:0] ctl_wdata_i,
  output logic [CTL_W-1:0] ctl_q_o,
  output logic             regs_rst_o,
  output logic             tx_rst_o,
  output logic             rx_rst_o,
  output logic             phy_busy_o
);
  logic pin_hit, cmd_busy, lock_busy, full_req;
  ctl_t ctl;

  rst_pin_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_CYC(FILT_CYC)) u_pin (
    .clk(clk), .por_i(por_i), .pin_n_i(ext_rst_n_i), .hit_o(pin_hit)
  );

  rst_hold_timer #(.LEN(CMD_HOLD)) u_cmd (
    .clk(clk), .clr_i(por_i), .load_i(host_rst_i), .busy_o(cmd_busy)
  );

  assign full_req = por_i | pin_hit | cmd_busy;

  rst_hold_timer #(.LEN(LOCK_CYC)) u_lock (
    .clk(clk), .clr_i(1'b0), .load_i(full_req), .busy_o(lock_busy)
  );

  rst_part_ctl u_ctl (
    .clk(clk), .full_i(full_req), .we_i(ctl_we_i),
    .wdata_i(ctl_wdata_i), .ctl_o(ctl)
  );

  logic regs_q, tx_q, rx_q, busy_q;

  always_ff @(posedge clk) begin
    regs_q <= full_req;
    tx_q   <= full_req | ctl.tx_rst;
    rx_q   <= full_req | ctl.rx_rst;
    busy_q <= full_req | lock_busy;
  end

  assign ctl_q_o    = ctl;
  assign regs_rst_o = regs_q;
  assign tx_rst_o   = tx_q;
  assign rx_rst_o   = rx_q;
  assign phy_busy_o = busy_q;
endmodule

// File: rtl/rst_ctrl_unit_chk.sv
module rst_ctrl_unit_chk (
  input logic       clk,
  input logic       por_i,
  input logic [3:0] ctl_q_o,
  input logic       regs_rst_o,
  input logic       tx_rst_o,
  input logic       rx_rst_o,
  input logic       phy_busy_o
);
  // R5
  full_covers_paths_chk: assert property (@(posedge clk) disable iff (por_i)
    regs_rst_o |-> (tx_rst_o && rx_rst_o));

  // R6
  tx_req_cleared_chk: assert property (@(posedge clk) disable iff (por_i)
    !(ctl_q_o[0] && ctl_q_o[2]));

  // R7
  rx_en_cleared_chk: assert property (@(posedge clk) disable iff (por_i)
    !(ctl_q_o[1] && ctl_q_o[3]));

  // R8
  tx_held_chk: assert property (@(posedge clk) disable iff (por_i)
    ctl_q_o[0] |=> tx_rst_o);

  // R8
  rx_held_chk: assert property (@(posedge clk) disable iff (por_i)
    ctl_q_o[1] |=> rx_rst_o);

  // R10
  busy_during_rst_chk: assert property (@(posedge clk) disable iff (por_i)
    regs_rst_o |-> phy_busy_o);

  // R10
  busy_after_release_chk: assert property (@(posedge clk) disable iff (por_i)
    $fell(regs_rst_o) |-> phy_busy_o);
endmodule

bind rst_ctrl_unit rst_ctrl_unit_chk u_chk (
  .clk(clk), .por_i(por_i), .ctl_q_o(ctl_q_o), .regs_rst_o(regs_rst_o),
  .tx_rst_o(tx_rst_o), .rx_rst_o(rx_rst_o), .phy_busy_o(phy_busy_o)
);

// File: tb/rst_ctrl_unit_tb.sv
module rst_ctrl_unit_tb;
  localparam int FILT = 8;
  localparam int HOLD = 4;
  localparam int LOCK = 40;

  logic clk = 1'b0;
  logic por = 1'b1, pin_n = 1'b1, hrst = 1'b0, we = 1'b0;
  logic [3:0] wd = '0;
  logic [3:0] ctl_q;
  logic regs_rst, tx_rst, rx_rst, busy;

  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rst_ctrl_unit #(.FILT_CYC(FILT), .CMD_HOLD(HOLD), .LOCK_CYC(LOCK)) u_dut (
    .clk(clk), .por_i(por), .ext_rst_n_i(pin_n), .host_rst_i(hrst),
    .ctl_we_i(we), .ctl_wdata_i(wd), .ctl_q_o(ctl_q), .regs_rst_o(regs_rst),
    .tx_rst_o(tx_rst), .rx_rst_o(rx_rst), .phy_busy_o(busy)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] d);
    we = 1'b1; wd = d; tick(); we = 1'b0; tick(); tick();
  endtask

  // measure busy cycles after regs_rst_o falls
  task automatic busy_len(output int n);
    n = 0;
    while (regs_rst) tick();
    while (busy && n < 4 * LOCK) begin n++; tick(); end
  endtask

  // {wdata, expected ctl, tx_rst, rx_rst, tag}
  localparam logic [13:0] VEC [8] = '{
    {4'b1100, 4'b1100, 1'b0, 1'b0, 4'd8},
    {4'b1101, 4'b1001, 1'b1, 1'b0, 4'd6},
    {4'b1001, 4'b1001, 1'b1, 1'b0, 4'd8},
    {4'b1000, 4'b1000, 1'b0, 1'b0, 4'd8},
    {4'b1110, 4'b0110, 1'b0, 1'b1, 4'd7},
    {4'b0100, 4'b0100, 1'b0, 1'b0, 4'd8},
    {4'b1111, 4'b0011, 1'b1, 1'b1, 4'd6},
    {4'b0000, 4'b0000, 1'b0, 1'b0, 4'd8}
  };

  function automatic string tag(input int t);
    case (t)
      6: return "R6";
      7: return "R7";
      default: return "R8";
    endcase
  endfunction

  initial begin
    repeat (3) tick();
    // R1 power-on state
    chk("R1 regs", regs_rst, 1); chk("R1 tx", tx_rst, 1);
    chk("R1 rx", rx_rst, 1);     chk("R1 busy", busy, 1);
    chk("R1 ctl", ctl_q, 0);
    por = 1'b0;
    begin
      int n; busy_len(n);
      // R10 lockout after power-on
      chk("R10 lock len", n, LOCK);
    end
    chk("R10 busy low", busy, 0);

    // vector table for partial resets
    foreach (VEC[i]) begin
      wr(VEC[i][13:10]);
      chk({tag(VEC[i][3:0]), " ctl"}, ctl_q, VEC[i][9:6]);
      chk({tag(VEC[i][3:0]), " tx"}, tx_rst, VEC[i][5]);
      chk({tag(VEC[i][3:0]), " rx"}, rx_rst, VEC[i][4]);
      // R9 no register reset, no lockout
      chk("R9 regs", regs_rst, 0);
      chk("R9 busy", busy, 0);
    end

    // R3 short glitch ignored
    wr(4'b1100);
    begin
      int seen = 0;
      pin_n = 1'b0;
      repeat (FILT - 1) begin tick(); seen |= regs_rst; end
      pin_n = 1'b1;
      repeat (6) begin tick(); seen |= regs_rst; end
      chk("R3 no reset", seen, 0);
      chk("R3 ctl kept", ctl_q, 4'b1100);
    end

    // R2 long low causes full reset, R5 side effects
    wr(4'b1001);
    begin
      int seen = 0, paths = 1;
      pin_n = 1'b0;
      repeat (FILT + 4) begin
        tick(); seen |= regs_rst;
        if (regs_rst && !(tx_rst && rx_rst)) paths = 0;
      end
      pin_n = 1'b1;
      chk("R2 reset seen", seen, 1);
      chk("R5 paths", paths, 1);
      chk("R5 ctl cleared", ctl_q, 0);
    end
    begin int n; busy_len(n); end
    repeat (4) tick();

    // R4 host command length
    wr(4'b1100);
    begin
      int cnt = 0;
      hrst = 1'b1; tick(); hrst = 1'b0;
      repeat (HOLD + 6) begin tick(); cnt += regs_rst; end
      chk("R4 hold", cnt, HOLD);
      chk("R5 ctl host", ctl_q, 0);
    end
    begin int n; busy_len(n); chk("R10 host lock", n, LOCK - 5); end
    repeat (4) tick();

    // R11 restart of lockout
    hrst = 1'b1; tick(); hrst = 1'b0;
    while (regs_rst || !busy) tick();
    repeat (LOCK / 2) tick();
    chk("R11 still busy", busy, 1);
    hrst = 1'b1; tick(); hrst = 1'b0;
    tick(); tick();
    begin int n; busy_len(n); chk("R11 restart", n, LOCK); end

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule